// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the raster timing for a display in the video clock domain. It drives horizontal sync, vertical sync, a data-enable strobe, and separate horizontal-active and vertical-active flags. It also passes pixel data through to the output so that the data lines up with data enable. Run-time settings arrive on three packed 32-bit words (active size, back porch and front porch) plus separate inputs for sync pulse widths and for total pixels per line and total lines per frame.

The settings are captured on the cycle in which enable rises. After that, a pixel counter and a line counter sweep the raster. Each line runs in this order: sync pulse, back porch, active video, front porch. Each frame runs in the same order, counted in lines.

One cycle before a pixel is shown, the block raises a read strobe towards an upstream first-word-fall-through buffer. The word that the buffer presents in that cycle is registered and appears on the RGB output together with data enable. All display outputs are registered and lag the counter state by one cycle. The read strobe is decoded straight from the counter state.

Top module: `vid_sync_gen`

## Requirements
- R1: In each of `res_word`, `bp_word` and `fp_word`, bits [15:0] hold the horizontal value and bits [31:16] hold the vertical value.
- R2: All settings are captured on the clock edge where `en` is high and the block was idle. Changes to any setting input while running have no effect on the outputs until enable falls and rises again.
- R3: The pixel counter runs from 0 to `htotal`-1 and wraps. The line counter advances only on that wrap and wraps after `vtotal`-1, so frames repeat identically.
- R4: Within a line, the horizontal sync is active for pixel counts [0, hsync width). `h_act` is high for counts [hsync+hbp, hsync+hbp+hres). The front porch follows.
- R5: Within a frame, the vertical sync is active for line counts [0, vsync width). `v_act` is high for lines [vsync+vbp, vsync+vbp+vres).
- R6: The active level of each sync is set by its own parameter (`HS_POL`, `VS_POL`; 1 = active high). The defaults are active low, so with the defaults an asserted sync reads 0 and an idle sync reads 1.
- R7: `de` is high exactly when both `h_act` and `v_act` are high.
- R8: `pix_rd` is high in exactly the cycle before each `de` cycle. `rgb` equals the `pix_in` value that was present while `pix_rd` was high. `rgb` is zero whenever `de` is low.
- R9: While `en` is low, both counters are held at zero. From the second cycle after enable falls, the syncs are inactive and `h_act`, `v_act`, `de`, `pix_rd` and `rgb` are all zero.
- R10: The default widths support a 2048-pixel-wide active line and a 1536-line-high active frame.
- R11: During reset and after it (with `en` low), the syncs are inactive and all other outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; a rising edge captures the settings |
| res_word | input | 32 | Active size, vertical in [31:16], horizontal in [15:0] |
| bp_word | input | 32 | Back porch, vertical in [31:16], horizontal in [15:0] |
| fp_word | input | 32 | Front porch, vertical in [31:16], horizontal in [15:0] |
| hsync_w | input | HW | Horizontal sync width in pixels |
| vsync_w | input | VW | Vertical sync width in lines |
| htotal | input | HW | Pixels per line |
| vtotal | input | VW | Lines per frame |
| pix_in | input | PIX_W | Head word of the upstream pixel buffer |
| pix_rd | output | 1 | Pop strobe to the upstream buffer |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| h_act | output | 1 | Horizontal active video flag |
| v_act | output | 1 | Vertical active video flag |
| de | output | 1 | Data enable |
| rgb | output | PIX_W | Pixel output, zero outside active video |

## Verification
The hardest condition to reach is a change to the setting inputs while the raster is running, because the outputs must show no trace of it. The bench reaches it by scrambling every setting input one cycle into a run. The scoreboard still expects the timing captured at the enable edge. The maximum sizes are reached with two lopsided runs, so each stays short: one has a 2048-pixel line over a few lines, and the other has 1536 active lines of a four-pixel width.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  // Timing of one axis, all fields widened to 16 bits.
  typedef struct packed {
    logic [15:0] sync;
    logic [15:0] bp;
    logic [15:0] act;
    logic [15:0] fp;
    logic [15:0] total;
  } vsg_axis_t;

  function automatic logic [15:0] lo_half(input logic [31:0] w);
    return w[15:0];
  endfunction

  function automatic logic [15:0] hi_half(input logic [31:0] w);
    return w[31:16];
  endfunction

  // Count lies inside the sync pulse.
  function automatic logic in_sync(input logic [15:0] c, input vsg_axis_t a);
    return c < a.sync;
  endfunction

  // Count lies inside [sync+bp, sync+bp+act).
  function automatic logic in_active(input logic [15:0] c, input vsg_axis_t a);
    logic [17:0] first;
    logic [17:0] stop;
    first = {2'b00, a.sync} + {2'b00, a.bp};
    stop  = first + {2'b00, a.act};
    return ({2'b00, c} >= first) && ({2'b00, c} < stop);
  endfunction

endpackage

// File: rtl/vsg_cfg_latch.sv
module vsg_cfg_latch
  import vsg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [31:0]   res_word,
  input  logic [31:0]   bp_word,
  input  logic [31:0]   fp_word,
  input  logic [HW-1:0] hsync_w,
  input  logic [VW-1:0] vsync_w,
  input  logic [HW-1:0] htotal,
  input  logic [VW-1:0] vtotal,
  output logic          run,
  output vsg_axis_t     hcfg,
  output vsg_axis_t     vcfg
);

  logic cfg_load;
  assign cfg_load = en & ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hcfg <= '0;
      vcfg <= '0;
    end else begin
      run <= en;
      if (cfg_load) begin
        hcfg <= '{sync: {{(16-HW){1'b0}}, hsync_w}, bp: lo_half(bp_word),
                  act: lo_half(res_word), fp: lo_half(fp_word),
                  total: {{(16-HW){1'b0}}, htotal}};
        vcfg <= '{sync: {{(16-VW){1'b0}}, vsync_w}, bp: hi_half(bp_word),
                  act: hi_half(res_word), fp: hi_half(fp_word),
                  total: {{(16-VW){1'b0}}, vtotal}};
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(hcfg) && $stable(vcfg))); // R2

endmodule

// File: rtl/vsg_axis_ctr.sv
module vsg_axis_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  assign wrap = step && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= wrap ? '0 : cnt + 1'b1;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $past(!clr) |-> (cnt <= last)); // R3

endmodule

// File: rtl/vsg_out_stage.sv
module vsg_out_stage #(
  parameter int   PIX_W  = 24,
  parameter logic HS_POL = 1'b0,
  parameter logic VS_POL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             h_sync_c,
  input  logic             v_sync_c,
  input  logic             h_act_c,
  input  logic             v_act_c,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_rd,
  output logic             hsync,
  output logic             vsync,
  output logic             h_act,
  output logic             v_act,
  output logic             de,
  output logic [PIX_W-1:0] rgb
);

  logic hs_lvl;
  logic vs_lvl;

  generate
    if (HS_POL) begin : g_hs_hi
      assign hs_lvl = h_sync_c;
    end else begin : g_hs_lo
      assign hs_lvl = ~h_sync_c;
    end
    if (VS_POL) begin : g_vs_hi
      assign vs_lvl = v_sync_c;
    end else begin : g_vs_lo
      assign vs_lvl = ~v_sync_c;
    end
  endgenerate

  assign pix_rd = h_act_c & v_act_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync <= ~HS_POL;
      vsync <= ~VS_POL;
      h_act <= 1'b0;
      v_act <= 1'b0;
      de    <= 1'b0;
      rgb   <= '0;
    end else begin
      hsync <= hs_lvl;
      vsync <= vs_lvl;
      h_act <= h_act_c;
      v_act <= v_act_c;
      de    <= pix_rd;
      rgb   <= pix_rd ? pix_in : '0;
    end
  end

  AST_DE_BOTH_AXES: assert property (@(posedge clk) disable iff (!rst_n)
    de == (h_act & v_act)); // R7
  AST_RD_LEADS_DE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd |=> de); // R8
  AST_DE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> $past(pix_rd)); // R8
  AST_BLANK_RGB: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (hsync == ~HS_POL && vsync == ~VS_POL && !de && !pix_rd)); // R9

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vsg_pkg::*;
#(
  parameter int   HW     = 12,
  parameter int   VW     = 11,
  parameter int   PIX_W  = 24,
  parameter logic HS_POL = 1'b0,
  parameter logic VS_POL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [31:0]      res_word,
  input  logic [31:0]      bp_word,
  input  logic [31:0]      fp_word,
  input  logic [HW-1:0]    hsync_w,
  input  logic [VW-1:0]    vsync_w,
  input  logic [HW-1:0]    htotal,
  input  logic [VW-1:0]    vtotal,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_rd,
  output logic             hsync,
  output logic             vsync,
  output logic             h_act,
  output logic             v_act,
  output logic             de,
  output logic [PIX_W-1:0] rgb
);

  localparam int CW = 16;

  logic      run;
  vsg_axis_t hcfg;
  vsg_axis_t vcfg;
  logic [CW-1:0] hcnt, vcnt;
  logic [CW-1:0] hlast, vlast;
  logic      h_wrap, v_wrap;
  logic      h_sync_c, v_sync_c, h_act_c, v_act_c;

  vsg_cfg_latch #(.HW(HW), .VW(VW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en),
    .res_word(res_word), .bp_word(bp_word), .fp_word(fp_word),
    .hsync_w(hsync_w), .vsync_w(vsync_w), .htotal(htotal), .vtotal(vtotal),
    .run(run), .hcfg(hcfg), .vcfg(vcfg)
  );

  assign hlast = hcfg.total - 16'd1;
  assign vlast = vcfg.total - 16'd1;

  vsg_axis_ctr #(.CW(CW)) u_hctr (
    .clk(clk), .rst_n(rst_n), .clr(~run), .step(1'b1),
    .last(hlast), .cnt(hcnt), .wrap(h_wrap)
  );

  vsg_axis_ctr #(.CW(CW)) u_vctr (
    .clk(clk), .rst_n(rst_n), .clr(~run), .step(h_wrap),
    .last(vlast), .cnt(vcnt), .wrap(v_wrap)
  );

  assign h_sync_c = run && in_sync(hcnt, hcfg);
  assign v_sync_c = run && in_sync(vcnt, vcfg);
  assign h_act_c  = run && in_active(hcnt, hcfg);
  assign v_act_c  = run && in_active(vcnt, vcfg);

  vsg_out_stage #(.PIX_W(PIX_W), .HS_POL(HS_POL), .VS_POL(VS_POL)) u_out (
    .clk(clk), .rst_n(rst_n), .run(run),
    .h_sync_c(h_sync_c), .v_sync_c(v_sync_c), .h_act_c(h_act_c), .v_act_c(v_act_c),
    .pix_in(pix_in), .pix_rd(pix_rd),
    .hsync(hsync), .vsync(vsync), .h_act(h_act), .v_act(v_act), .de(de), .rgb(rgb)
  );

  AST_LINE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !run)
    !$stable(vcnt) |-> $past(h_wrap)); // R3
  AST_FRAME_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !run)
    $past(v_wrap && run) |-> (vcnt == '0 && hcnt == '0)); // R3

endmodule

// File: tb/vid_sync_gen_test.sv
module vid_sync_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] res_word = '0, bp_word = '0, fp_word = '0;
  logic [11:0] hsync_w = '0, htotal = '0;
  logic [10:0] vsync_w = '0, vtotal = '0;
  logic [23:0] pix_in;
  logic        pix_rd, hsync, vsync, h_act, v_act, de;
  logic [23:0] rgb;

  always #5 clk = ~clk;

  vid_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .res_word(res_word), .bp_word(bp_word), .fp_word(fp_word),
    .hsync_w(hsync_w), .vsync_w(vsync_w), .htotal(htotal), .vtotal(vtotal),
    .pix_in(pix_in), .pix_rd(pix_rd), .hsync(hsync), .vsync(vsync),
    .h_act(h_act), .v_act(v_act), .de(de), .rgb(rgb)
  );

  typedef struct {
    logic hs; logic vs; logic ha; logic va; logic de; logic [23:0] rgb;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  int rd_cnt = 0;

  function automatic logic [23:0] pixf(input int k);
    return 24'((k * 40503) + 291);
  endfunction

  // First-word-fall-through buffer model: head word advances after each pop.
  always @(posedge clk) begin
    if (!en) rd_cnt <= 0;
    else if (pix_rd) rd_cnt <= rd_cnt + 1;
  end
  assign pix_in = pixf(rd_cnt);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Monitor: pops one expected raster position per cycle.
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R4", "hsync", {31'b0, hsync}, {31'b0, e.hs});
      chk("R5", "vsync", {31'b0, vsync}, {31'b0, e.vs});
      chk("R4", "h_act", {31'b0, h_act}, {31'b0, e.ha});
      chk("R5", "v_act", {31'b0, v_act}, {31'b0, e.va});
      chk("R7", "de", {31'b0, de}, {31'b0, e.de});
      chk("R8", "rgb", {8'b0, rgb}, {8'b0, e.rgb});
      if (q.size() > 0) chk("R8", "pix_rd", {31'b0, pix_rd}, {31'b0, q[0].de});
    end
  end

  // Driver: expected raster, sync active low (R6 defaults).
  task automatic push_frames(input int hs, input int hb, input int hr, input int hf,
                             input int vs, input int vb, input int vr, input int vf,
                             input int frames);
    int ht, vt, k;
    ht = hs + hb + hr + hf;
    vt = vs + vb + vr + vf;
    k = 0;
    for (int f = 0; f < frames; f++)
      for (int v = 0; v < vt; v++)
        for (int h = 0; h < ht; h++) begin
          exp_t e;
          e.hs = !(h < hs);
          e.vs = !(v < vs);
          e.ha = (h >= hs + hb) && (h < hs + hb + hr);
          e.va = (v >= vs + vb) && (v < vs + vb + vr);
          e.de = e.ha && e.va;
          e.rgb = e.de ? pixf(k) : 24'h0;
          if (e.de) k++;
          q.push_back(e);
        end
  endtask

  task automatic idle_checks(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "idle hsync", {31'b0, hsync}, 32'd1);
      chk(req, "idle vsync", {31'b0, vsync}, 32'd1);
      chk(req, "idle de", {31'b0, de}, 32'd0);
      chk(req, "idle h_act", {31'b0, h_act}, 32'd0);
      chk(req, "idle v_act", {31'b0, v_act}, 32'd0);
      chk(req, "idle pix_rd", {31'b0, pix_rd}, 32'd0);
      chk(req, "idle rgb", {8'b0, rgb}, 32'd0);
    end
  endtask

  task automatic run_case(input int hs, input int hb, input int hr, input int hf,
                          input int vs, input int vb, input int vr, input int vf,
                          input int frames, input bit scramble);
    @(negedge clk);
    // R1: vertical in the upper half, horizontal in the lower half.
    res_word = {16'(vr), 16'(hr)};
    bp_word  = {16'(vb), 16'(hb)};
    fp_word  = {16'(vf), 16'(hf)};
    hsync_w  = 12'(hs);
    vsync_w  = 11'(vs);
    htotal   = 12'(hs + hb + hr + hf);
    vtotal   = 11'(vs + vb + vr + vf);
    push_frames(hs, hb, hr, hf, vs, vb, vr, vf, frames);
    en = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 mon_on = 1'b1;
    if (scramble) begin
      // R2: settings changed mid-run must not show.
      #2;
      res_word = 32'h0003_0002;
      bp_word  = 32'h0007_0009;
      fp_word  = 32'h0001_0005;
      hsync_w  = 12'd7;
      vsync_w  = 11'd3;
      htotal   = 12'd31;
      vtotal   = 11'd9;
    end
    wait (q.size() == 0);
    mon_on = 1'b0;
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    idle_checks("R9", 12);
  endtask

  initial begin
    #1_500_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_checks("R11", 1);
    rst_n = 1'b1;
    idle_checks("R11", 3);
    // Two frames to cover counter wrap of both axes (R3).
    run_case(2, 3, 12, 3, 1, 2, 8, 1, 2, 1'b0);
    run_case(4, 1, 6, 2, 2, 1, 4, 2, 1, 1'b1);
    // One-pixel sync with no porches.
    run_case(1, 0, 9, 0, 1, 0, 5, 0, 1, 1'b0);
    // R10: widest line, then tallest frame.
    run_case(44, 148, 2048, 88, 1, 1, 2, 1, 1, 1'b0);
    run_case(1, 1, 1, 1, 5, 36, 1536, 3, 1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule